// File: doc/BRIEF.md
# Vector Compare Predicate Generator

This block executes a compare-and-branch operation whose meaning depends on tags attached to its two source registers. When neither source is tagged as a vector, it reads the two registers, compares them and reports a branch decision. When at least one source is tagged, no branch is taken. The block walks through the active vector length one element per cycle. It compares element pairs and collects the outcomes into a predicate bitmask. It then writes that mask into an integer register, whose number comes from the field that the scalar form uses as its branch offset.

The block drives both read addresses of an external register file and expects the read data back combinationally in the same cycle. It drives one write port for the mask. Its controller is a four-state machine:

- `ST_IDLE`: waits for `issue`.
- `ST_BRANCH`: one scalar compare cycle.
- `ST_ELEM`: one cycle per vector element.
- `ST_WRITE`: the single mask write-back.

The transitions are:

- idle→branch on an issue with no tagged operand.
- idle→elem on a vector issue with an effective length of at least 1.
- idle→write on a vector issue with an effective length of 0.
- elem→elem while elements remain.
- elem→write after the last element.
- branch→idle and write→idle unconditionally.

Top module: `vcp_top`

## Requirements
- R1: After reset, `busy`, `br_valid` and `rf_we` are all low.
- R2: An issue with neither `src1_vec` nor `src2_vec` set produces exactly one `br_valid` pulse, in the cycle after the issue edge. `br_taken` in that pulse is the comparison of register `src1_idx` against register `src2_idx`, and no register write occurs.
- R3: `cmp_op` selects the test of src1 against src2. The codes are 0 for equal, 1 for not-equal, 2 for signed less-than and 3 for unsigned less-than, on XLEN-bit values.
- R4: In vector mode, element i reads register (`src1_idx`+i) mod NREG when `src1_vec` is set, and register `src1_idx` for every element otherwise. The same rule applies to src2.
- R5: Bit i of the written mask is the comparison result of element i. All bits at and above the effective vector length are zero.
- R6: A vector issue with effective length L≥1 produces exactly one write, to register `tgt_idx`, L+1 cycles after the issue edge. With L=0 it produces one write of an all-zero mask 1 cycle after the issue edge.
- R7: During a vector operation `br_valid` never rises.
- R8: A `vl` above MAX_VL is treated as MAX_VL.
- R9: `issue` is ignored while `busy` is high. It neither alters the operation in progress nor starts another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Start request, taken only when idle |
| src1_idx | input | $clog2(NREG) | First source register number |
| src2_idx | input | $clog2(NREG) | Second source register number |
| src1_vec | input | 1 | First source tagged as vector |
| src2_vec | input | 1 | Second source tagged as vector |
| vl | input | $clog2(MAX_VL+1) | Requested vector length |
| cmp_op | input | 2 | Comparison code |
| tgt_idx | input | $clog2(NREG) | Mask destination register (branch offset field) |
| rf_raddr1 | output | $clog2(NREG) | Read address, first operand |
| rf_rdata1 | input | XLEN | Read data, first operand |
| rf_raddr2 | output | $clog2(NREG) | Read address, second operand |
| rf_rdata2 | input | XLEN | Read data, second operand |
| busy | output | 1 | Operation in progress |
| br_valid | output | 1 | Scalar branch decision valid |
| br_taken | output | 1 | Branch taken (meaningful with br_valid) |
| rf_we | output | 1 | Mask write enable |
| rf_waddr | output | $clog2(NREG) | Mask write register |
| rf_wdata | output | XLEN | Mask value, zero-extended |

## Verification
Two things can coincide in one cycle: the mask write-back of one operation and a fresh issue request for the next. The bench asserts `issue` with different fields in exactly the write cycle of a subset of vector runs. It then expects the write to carry the original register and mask, and expects no second operation, branch pulse or write to follow. A correct design returns to idle with `busy` low the cycle after the write.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BRANCH = 2'd1,
        ST_ELEM   = 2'd2,
        ST_WRITE  = 2'd3
    } vcp_state_e;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'd0,
        CMP_NE  = 2'd1,
        CMP_LT  = 2'd2,
        CMP_LTU = 2'd3
    } vcp_cmp_e;

endpackage

// File: rtl/vcp_compare.sv
module vcp_compare #(
    parameter int XLEN = 16
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic            hit
);
    import vcp_pkg::*;

    vcp_cmp_e op_e;
    assign op_e = vcp_cmp_e'(op);

    always_comb begin
        unique case (op_e)
            CMP_EQ:  hit = (lhs == rhs);
            CMP_NE:  hit = (lhs != rhs);
            CMP_LT:  hit = ($signed(lhs) < $signed(rhs));
            CMP_LTU: hit = (lhs < rhs);
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/vcp_addr_gen.sv
module vcp_addr_gen #(
    parameter int RAW = 5,
    parameter int VLW = 4
) (
    input  logic [RAW-1:0] base1,
    input  logic [RAW-1:0] base2,
    input  logic           vec1,
    input  logic           vec2,
    input  logic [VLW-1:0] elem,
    output logic [RAW-1:0] addr1,
    output logic [RAW-1:0] addr2
);
    localparam int NPORT = 2;

    logic [RAW-1:0] base_a [NPORT];
    logic           vec_a  [NPORT];
    logic [RAW-1:0] addr_a [NPORT];

    assign base_a[0] = base1;
    assign base_a[1] = base2;
    assign vec_a[0]  = vec1;
    assign vec_a[1]  = vec2;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        // Tagged operands step through consecutive registers; modulo NREG by truncation.
        assign addr_a[g] = vec_a[g] ? RAW'(base_a[g] + RAW'(elem)) : base_a[g];
    end

    assign addr1 = addr_a[0];
    assign addr2 = addr_a[1];

endmodule

// File: rtl/vcp_mask_acc.sv
module vcp_mask_acc #(
    parameter int MW  = 8,
    parameter int VLW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           en,
    input  logic [VLW-1:0] elem,
    input  logic           hit,
    output logic [MW-1:0]  mask
);
    logic [MW-1:0] mask_q;

    for (genvar g = 0; g < MW; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g] <= 1'b0;
            end else if (clear) begin
                mask_q[g] <= 1'b0;
            end else if (en && (elem == VLW'(g))) begin
                mask_q[g] <= hit;
            end
        end
    end

    assign mask = mask_q;

    // R5: a fresh operation starts from an empty mask
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mask == '0));

    // R5: an element update touches only its own bit
    a_r5_one_bit_per_elem: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear) |=> ($countones(mask ^ $past(mask)) <= 1));

endmodule

// File: rtl/vcp_top.sv
module vcp_top #(
    parameter int XLEN   = 16,
    parameter int NREG   = 32,
    parameter int MAX_VL = 8,
    localparam int RAW   = $clog2(NREG),
    localparam int VLW   = $clog2(MAX_VL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [RAW-1:0]  src1_idx,
    input  logic [RAW-1:0]  src2_idx,
    input  logic            src1_vec,
    input  logic            src2_vec,
    input  logic [VLW-1:0]  vl,
    input  logic [1:0]      cmp_op,
    input  logic [RAW-1:0]  tgt_idx,
    output logic [RAW-1:0]  rf_raddr1,
    input  logic [XLEN-1:0] rf_rdata1,
    output logic [RAW-1:0]  rf_raddr2,
    input  logic [XLEN-1:0] rf_rdata2,
    output logic            busy,
    output logic            br_valid,
    output logic            br_taken,
    output logic            rf_we,
    output logic [RAW-1:0]  rf_waddr,
    output logic [XLEN-1:0] rf_wdata
);
    import vcp_pkg::*;

    vcp_state_e     state_q, state_d;
    logic [RAW-1:0] s1_q, s2_q, tgt_q;
    logic           v1_q, v2_q;
    logic [VLW-1:0] vl_q, idx_q;
    logic [1:0]     op_q;
    logic [VLW-1:0] vl_eff;
    logic           accept;
    logic           any_vec;
    logic           last_elem;
    logic           hit;
    logic [MAX_VL-1:0] mask;

    assign vl_eff    = (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;
    assign accept    = (state_q == ST_IDLE) && issue;
    assign any_vec   = src1_vec || src2_vec;
    assign last_elem = (VLW'(idx_q + VLW'(1)) == vl_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue) begin
                    if (!any_vec)            state_d = ST_BRANCH;
                    else if (vl_eff == '0)   state_d = ST_WRITE;
                    else                     state_d = ST_ELEM;
                end
            end
            ST_BRANCH: state_d = ST_IDLE;
            ST_ELEM:   state_d = last_elem ? ST_WRITE : ST_ELEM;
            ST_WRITE:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operand capture and element counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= '0;
            s2_q  <= '0;
            tgt_q <= '0;
            v1_q  <= 1'b0;
            v2_q  <= 1'b0;
            vl_q  <= '0;
            op_q  <= '0;
            idx_q <= '0;
        end else if (accept) begin
            s1_q  <= src1_idx;
            s2_q  <= src2_idx;
            tgt_q <= tgt_idx;
            v1_q  <= src1_vec;
            v2_q  <= src2_vec;
            vl_q  <= vl_eff;
            op_q  <= cmp_op;
            idx_q <= '0;
        end else if (state_q == ST_ELEM) begin
            idx_q <= VLW'(idx_q + VLW'(1));
        end
    end

    vcp_addr_gen #(.RAW(RAW), .VLW(VLW)) u_addr (
        .base1 (s1_q),
        .base2 (s2_q),
        .vec1  (v1_q),
        .vec2  (v2_q),
        .elem  (idx_q),
        .addr1 (rf_raddr1),
        .addr2 (rf_raddr2)
    );

    vcp_compare #(.XLEN(XLEN)) u_cmp (
        .op  (op_q),
        .lhs (rf_rdata1),
        .rhs (rf_rdata2),
        .hit (hit)
    );

    vcp_mask_acc #(.MW(MAX_VL), .VLW(VLW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .en    (state_q == ST_ELEM),
        .elem  (idx_q),
        .hit   (hit),
        .mask  (mask)
    );

    // Outputs decoded from the state
    always_comb begin
        busy     = 1'b0;
        br_valid = 1'b0;
        br_taken = 1'b0;
        rf_we    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_BRANCH: begin
                busy     = 1'b1;
                br_valid = 1'b1;
                br_taken = hit;
            end
            ST_ELEM:   busy = 1'b1;
            ST_WRITE: begin
                busy  = 1'b1;
                rf_we = 1'b1;
            end
            default:   ;
        endcase
        rf_waddr = tgt_q;
        rf_wdata = XLEN'(mask);
    end

    // R7: vector operations never report a branch
    a_r7_no_branch_in_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (v1_q || v2_q)) |-> !br_valid);

    // R2: a branch decision lasts one cycle and never coincides with a write
    a_r2_branch_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> !br_valid);

    a_r2_branch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> !rf_we);

    // R6: one write per operation, then idle
    a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> (!rf_we && !busy));

    // R5: nothing above the effective length is set in the written mask
    a_r5_mask_above_vl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ((rf_wdata >> vl_q) == '0));

    // R9: a request while busy leaves the captured operation untouched
    a_r9_busy_issue_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && issue) |=> ($stable(tgt_q) && $stable(op_q) && $stable(vl_q)));

    // R8: the captured length never exceeds the maximum
    a_r8_vl_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (vl_q <= VLW'(MAX_VL)));

endmodule

// File: tb/tb_vcp_top.sv
`timescale 1ns/1ps
module tb_vcp_top;
    localparam int XLEN   = 16;
    localparam int NREG   = 32;
    localparam int MAX_VL = 8;
    localparam int RAW    = $clog2(NREG);
    localparam int VLW    = $clog2(MAX_VL + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue = 1'b0;
    logic [RAW-1:0]  src1_idx = '0, src2_idx = '0, tgt_idx = '0;
    logic            src1_vec = 1'b0, src2_vec = 1'b0;
    logic [VLW-1:0]  vl = '0;
    logic [1:0]      cmp_op = '0;
    logic [RAW-1:0]  rf_raddr1, rf_raddr2, rf_waddr;
    logic [XLEN-1:0] rf_rdata1, rf_rdata2, rf_wdata;
    logic            busy, br_valid, br_taken, rf_we;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    function automatic logic [XLEN-1:0] rf_val(input int k);
        if ((k % 4) == 0) return 16'h0042;
        return XLEN'(k * 40503 + 7);
    endfunction

    assign rf_rdata1 = rf_val(int'(rf_raddr1));
    assign rf_rdata2 = rf_val(int'(rf_raddr2));

    vcp_top #(.XLEN(XLEN), .NREG(NREG), .MAX_VL(MAX_VL)) dut (
        .clk(clk), .rst_n(rst_n), .issue(issue),
        .src1_idx(src1_idx), .src2_idx(src2_idx),
        .src1_vec(src1_vec), .src2_vec(src2_vec),
        .vl(vl), .cmp_op(cmp_op), .tgt_idx(tgt_idx),
        .rf_raddr1(rf_raddr1), .rf_rdata1(rf_rdata1),
        .rf_raddr2(rf_raddr2), .rf_rdata2(rf_rdata2),
        .busy(busy), .br_valid(br_valid), .br_taken(br_taken),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    function automatic logic exp_cmp(input int op, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        int sa, sb;
        sa = (a >= 16'h8000) ? int'(a) - 65536 : int'(a);
        sb = (b >= 16'h8000) ? int'(b) - 65536 : int'(b);
        case (op)
            0: return a == b;
            1: return a != b;
            2: return sa < sb;
            default: return int'(a) < int'(b);
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(input int op, input int s1, input int s2, input bit v1, input bit v2,
                          input int vlen, input int tgt, input bit collide);
        int veff, exp_mask, exp_lat, we_cnt, we_cyc, we_addr, we_data, bv_cnt, bv_cyc, bt_val;
        bit vec;
        vec  = v1 || v2;
        veff = (vlen > MAX_VL) ? MAX_VL : vlen;
        exp_mask = 0;
        for (int i = 0; i < veff; i++) begin
            int a1, a2;
            a1 = v1 ? (s1 + i) % NREG : s1;
            a2 = v2 ? (s2 + i) % NREG : s2;
            if (exp_cmp(op, rf_val(a1), rf_val(a2))) exp_mask |= (1 << i);
        end
        exp_lat = (veff == 0) ? 1 : veff + 1;
        @(negedge clk);
        src1_idx = RAW'(s1); src2_idx = RAW'(s2);
        src1_vec = v1; src2_vec = v2;
        vl = VLW'(vlen); cmp_op = 2'(op); tgt_idx = RAW'(tgt);
        issue = 1'b1;
        @(posedge clk);
        @(negedge clk);
        issue = 1'b0;
        we_cnt = 0; we_cyc = -1; we_addr = 0; we_data = 0; bv_cnt = 0; bv_cyc = -1; bt_val = 0;
        for (int c = 1; c <= MAX_VL + 6; c++) begin
            if (rf_we) begin
                we_cnt++;
                if (we_cyc < 0) begin we_cyc = c; we_addr = int'(rf_waddr); we_data = int'(rf_wdata); end
            end
            if (br_valid) begin
                bv_cnt++;
                if (bv_cyc < 0) begin bv_cyc = c; bt_val = int'(br_taken); end
            end
            // R9: new request exactly in the write-back cycle
            if (collide && vec && c == exp_lat) begin
                src1_idx = RAW'(s1 + 3); tgt_idx = RAW'(tgt + 1); vl = VLW'(2);
                src1_vec = 1'b0; src2_vec = 1'b0; issue = 1'b1;
            end
            if (collide && vec && c == exp_lat + 1) issue = 1'b0;
            @(negedge clk);
        end
        issue = 1'b0;
        check(!busy, "R9", "busy after op", int'(busy), 0);
        if (vec) begin
            check(bv_cnt == 0, "R7", "branch pulses in vector op", bv_cnt, 0);
            check(we_cnt == 1, "R6", "write count", we_cnt, 1);
            check(we_cyc == exp_lat, "R6", "write latency", we_cyc, exp_lat);
            check(we_addr == tgt, "R6", "write register", we_addr, tgt);
            check(we_data == exp_mask, (vlen > MAX_VL) ? "R8" : "R5", "mask", we_data, exp_mask);
        end else begin
            int eb;
            eb = int'(exp_cmp(op, rf_val(s1), rf_val(s2)));
            check(bv_cnt == 1 && bv_cyc == 1, "R2", "branch pulse timing", bv_cyc, 1);
            check(bt_val == eb, "R3", "branch taken", bt_val, eb);
            check(we_cnt == 0, "R2", "writes in scalar op", we_cnt, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !br_valid && !rf_we, "R1", "outputs in reset",
              int'({busy, br_valid, rf_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !br_valid && !rf_we, "R1", "outputs after reset",
              int'({busy, br_valid, rf_we}), 0);
        // R4 wrap-around: base near top of the file
        run_op(0, 30, 28, 1'b1, 1'b1, 8, 5, 1'b0);
        run_op(3, 29, 4, 1'b1, 1'b0, 8, 6, 1'b0);
        for (int op = 0; op < 4; op++)
            for (int tag = 0; tag < 4; tag++)
                for (int vlen = 0; vlen <= 9; vlen++)
                    run_op(op, (op * 7 + tag * 3 + vlen) % NREG,
                           (vlen * 5 + op + tag * 11) % NREG,
                           tag[0], tag[1], vlen, (op * 4 + tag + vlen * 3) % NREG,
                           (vlen % 3) == 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule